// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Controller

This block watches the current time and calendar of a real-time clock and raises an alarm when the time matches a programmed alarm. It compares six BCD time fields against six alarm fields: seconds, minutes, hours, date, month and weekday. Each alarm field carries its own compare-enable bit, so any subset of fields can take part. A field whose enable bit is clear always counts as matching. The compare runs once per 1 Hz update strobe. A match sets a sticky alarm flag and drives an active-low interrupt output.

The interrupt has two modes. In hold mode the output stays low for as long as the flag is set. In pulse mode every match pulls the output low for a fixed number of system-clock cycles, which gives recurring alarms. The host can clear the flag by writing a zero. The flag can also clear by itself when status is read, unless a match arrived during that same read. A frequency-output function, when active, takes over the shared interrupt pin.

Top module: `rtc_alarm_irq`

## Requirements
- R1: Field k of `now_fields` and of `alm_fields` occupies bits [8k+7:8k], in the order seconds (k=0), minutes, hours, date, month, weekday (k=5). Bit 7 of an alarm field enables its compare. Only bits 6:0 are compared, and bit 7 of a time field is ignored. A field with its enable bit clear counts as matching, so with no field enabled every update matches.
- R2: A match is evaluated only in a cycle where `tick_1hz` is 1. A matching update sets `alarm_flag` from the next cycle on. Matching inputs without a tick do not set the flag.
- R3: While `alarm_en` is 0, no update sets `alarm_flag`.
- R4: In hold mode (`irq_mode`=0), with `fout_active`=0, `irq_n` is low exactly while `alarm_flag` is 1.
- R5: In pulse mode (`irq_mode`=1), with `fout_active`=0, each match drives `irq_n` low for PULSE_TICKS cycles, starting the cycle after the tick. A new match during a pulse restarts the full length. In this mode `irq_n` does not follow the flag.
- R6: A `flag_wr` strobe with `flag_wr_bit`=0 clears `alarm_flag` on the next cycle. With `flag_wr_bit`=1 the strobe leaves the flag unchanged.
- R7: A `status_rd` strobe clears `alarm_flag` on the next cycle when `auto_clr_en`=1. It leaves the flag unchanged when `auto_clr_en`=0.
- R8: If a match occurs while `rd_busy` is 1, status-read strobes do not clear the flag until `rd_busy` has returned to 0.
- R9: When a match and a clear request arrive in the same cycle, the flag ends up set.
- R10: While `fout_active`=1, `irq_n` equals `fout_level`, and the alarm flag keeps its own behaviour.
- R11: After reset `alarm_flag` is 0, no pulse is running, and `irq_n` is 1 with `fout_active`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle strobe; time fields already hold the new second |
| now_fields | input | NUM_FIELDS*FIELD_W | Current BCD time fields |
| alm_fields | input | NUM_FIELDS*FIELD_W | Alarm fields, bit 7 of each is its enable |
| alarm_en | input | 1 | Master alarm enable |
| irq_mode | input | 1 | 0 hold mode, 1 pulse mode |
| auto_clr_en | input | 1 | Flag clears on status read |
| flag_wr | input | 1 | Host write strobe to the flag |
| flag_wr_bit | input | 1 | Value written; only 0 acts |
| status_rd | input | 1 | Status read strobe |
| rd_busy | input | 1 | A host read is in progress |
| fout_active | input | 1 | Frequency output owns the pin |
| fout_level | input | 1 | Frequency output waveform |
| alarm_flag | output | 1 | Sticky alarm flag |
| irq_n | output | 1 | Active-low interrupt / shared pin |

## Verification
The assertions assume that `tick_1hz`, `flag_wr` and `status_rd` are single-cycle strobes, and that the time fields are already settled in the cycle the tick arrives. The bench therefore raises each strobe for exactly one cycle. It changes every input shortly after a rising edge and holds it steady through the next edge. Pulse-length checks leave the tick low between matches, so each pulse is timed only by the restart rule.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int FIELD_W    = 8;
  localparam int NUM_FIELDS = 6;
  localparam logic [FIELD_W-1:0] CMP_MASK = {1'b0, {(FIELD_W-1){1'b1}}};

  typedef enum logic {IRQ_HOLD = 1'b0, IRQ_PULSE = 1'b1} irq_mode_e;

  // A field hits when its enable bit is clear or its BCD value agrees.
  function automatic logic field_hit(input logic [FIELD_W-1:0] now_v,
                                     input logic [FIELD_W-1:0] alm_v);
    return !alm_v[FIELD_W-1] || (((now_v ^ alm_v) & CMP_MASK) == '0);
  endfunction
endpackage

// File: rtl/alarm_field_cmp.sv
module alarm_field_cmp
  import rtc_alarm_pkg::*;
(
  input  logic [FIELD_W-1:0] now_v,
  input  logic [FIELD_W-1:0] alm_v,
  output logic               hit
);
  assign hit = field_hit(now_v, alm_v);
endmodule

// File: rtl/alarm_flag_ctl.sv
module alarm_flag_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic wr_stb,
  input  logic wr_bit,
  input  logic rd_stb,
  input  logic rd_busy,
  input  logic auto_clr_en,
  output logic flag
);
  logic shield;
  logic clr_host, clr_auto;

  assign clr_host = wr_stb && !wr_bit;
  assign clr_auto = rd_stb && auto_clr_en && !shield;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      shield <= 1'b0;
    end else begin
      if (set_evt)                   flag <= 1'b1;
      else if (clr_host || clr_auto) flag <= 1'b0;

      if (set_evt && rd_busy) shield <= 1'b1;
      else if (!rd_busy)      shield <= 1'b0;
    end
  end

  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    set_evt |=> flag);
  a_r6_write_one_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && wr_stb && wr_bit && !rd_stb) |=> flag);
  a_r8_shield_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && shield && rd_stb && !wr_stb) |=> flag);
  a_r7_fall_has_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag) |-> $past((wr_stb && !wr_bit) || (rd_stb && auto_clr_en)));
endmodule

// File: rtl/alarm_pulse_timer.sv
module alarm_pulse_timer #(
  parameter int PULSE_TICKS = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic active
);
  localparam int CW = $clog2(PULSE_TICKS + 1);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CW'(PULSE_TICKS);
    else if (cnt != '0)  cnt <= cnt - CW'(1);
  end

  assign active = (cnt != '0);

  a_r5_load_starts: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> active);
  a_r5_rise_from_load: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) |-> $past(load));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int NUM_F       = NUM_FIELDS,
  parameter int FW          = FIELD_W,
  parameter int PULSE_TICKS = 8192
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [NUM_F*FW-1:0] now_fields,
  input  logic [NUM_F*FW-1:0] alm_fields,
  input  logic              alarm_en,
  input  logic              irq_mode,
  input  logic              auto_clr_en,
  input  logic              flag_wr,
  input  logic              flag_wr_bit,
  input  logic              status_rd,
  input  logic              rd_busy,
  input  logic              fout_active,
  input  logic              fout_level,
  output logic              alarm_flag,
  output logic              irq_n
);
  logic [NUM_F-1:0] hits;
  logic             all_hit;
  logic             match_evt;
  logic             pulse_active;
  logic             alarm_low;
  irq_mode_e        mode;

  for (genvar k = 0; k < NUM_F; k++) begin : g_field
    alarm_field_cmp u_cmp (
      .now_v (now_fields[k*FW +: FW]),
      .alm_v (alm_fields[k*FW +: FW]),
      .hit   (hits[k])
    );
  end

  assign all_hit   = &hits;
  assign match_evt = tick_1hz && alarm_en && all_hit;
  assign mode      = irq_mode_e'(irq_mode);

  alarm_flag_ctl u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_evt     (match_evt),
    .wr_stb      (flag_wr),
    .wr_bit      (flag_wr_bit),
    .rd_stb      (status_rd),
    .rd_busy     (rd_busy),
    .auto_clr_en (auto_clr_en),
    .flag        (alarm_flag)
  );

  alarm_pulse_timer #(.PULSE_TICKS(PULSE_TICKS)) u_pulse (
    .clk    (clk),
    .rst_n  (rst_n),
    .load   (match_evt && (mode == IRQ_PULSE)),
    .active (pulse_active)
  );

  assign alarm_low = (mode == IRQ_PULSE) ? pulse_active : alarm_flag;
  assign irq_n     = fout_active ? fout_level : !alarm_low;

  a_r2_rise_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_flag) |-> $past(tick_1hz && alarm_en));
  a_r3_quiet_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    (!alarm_en && !alarm_flag) |=> !alarm_flag);
  a_r4_hold_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!fout_active && mode == IRQ_HOLD && !alarm_flag) |-> irq_n);
  a_r10_pin_override: assert property (@(posedge clk) disable iff (!rst_n)
    fout_active |-> (irq_n == fout_level));
endmodule

// File: tb/rtc_alarm_irq_test.sv
`timescale 1ns/1ps
module rtc_alarm_irq_test;
  localparam int P = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick_1hz = 0, alarm_en = 0, irq_mode = 0, auto_clr_en = 0;
  logic flag_wr = 0, flag_wr_bit = 0, status_rd = 0, rd_busy = 0;
  logic fout_active = 0, fout_level = 0;
  logic [47:0] now_fields = '0, alm_fields = '0;
  logic alarm_flag, irq_n;

  rtc_alarm_irq #(.PULSE_TICKS(P)) uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .now_fields(now_fields),
    .alm_fields(alm_fields), .alarm_en(alarm_en), .irq_mode(irq_mode),
    .auto_clr_en(auto_clr_en), .flag_wr(flag_wr), .flag_wr_bit(flag_wr_bit),
    .status_rd(status_rd), .rd_busy(rd_busy), .fout_active(fout_active),
    .fout_level(fout_level), .alarm_flag(alarm_flag), .irq_n(irq_n));

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    due_q[$];
  bit    ef_q[$];
  bit    ei_q[$];
  string tag_q[$];
  int    checks = 0, fails = 0;
  bit    done = 0;

  function automatic logic [47:0] tf(input logic [7:0] s, m, h, d, mo, w);
    return {w, mo, d, h, m, s};
  endfunction

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic expect_at(int d, bit f, bit i, string tag);
    due_q.push_back(cyc + d); ef_q.push_back(f); ei_q.push_back(i);
    tag_q.push_back(tag);
  endtask

  task automatic tick(logic [47:0] t);
    now_fields = t; tick_1hz = 1; step(); tick_1hz = 0;
  endtask

  task automatic wr_flag(bit b);
    flag_wr = 1; flag_wr_bit = b; step(); flag_wr = 0;
  endtask

  task automatic rd_status();
    status_rd = 1; step(); status_rd = 0;
  endtask

  // monitor: pops expected items as their cycle comes up
  always @(negedge clk) begin
    while (due_q.size() > 0 && due_q[0] <= cyc) begin
      checks++;
      if (due_q[0] < cyc) begin
        fails++;
        $display("FAIL %s: item missed at cycle %0d", tag_q[0], cyc);
      end else if (alarm_flag !== ef_q[0] || irq_n !== ei_q[0]) begin
        fails++;
        $display("FAIL %s: flag/irq_n actual %b/%b expected %b/%b",
                 tag_q[0], alarm_flag, irq_n, ef_q[0], ei_q[0]);
      end
      void'(due_q.pop_front()); void'(ef_q.pop_front());
      void'(ei_q.pop_front()); void'(tag_q.pop_front());
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    step();
    expect_at(0, 0, 1, "R11 reset state");

    // seconds = 30 enabled only
    alm_fields = tf(8'hB0, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00);
    alarm_en = 1;
    step();
    tick(tf(8'h29, 8'h12, 8'h92, 8'h01, 8'h01, 8'h01));
    expect_at(0, 0, 1, "R1 no match sec 29");
    tick(tf(8'hB0, 8'h12, 8'h92, 8'h01, 8'h01, 8'h01)); // time bit7 ignored
    expect_at(0, 1, 0, "R2 R4 match sec 30 hold");
    wr_flag(1);
    expect_at(0, 1, 0, "R6 write one ignored");
    wr_flag(0);
    expect_at(0, 0, 1, "R6 write zero clears");

    now_fields = tf(8'h30, 8'h12, 8'h00, 8'h01, 8'h01, 8'h01);
    repeat (3) step();
    expect_at(0, 0, 1, "R2 no tick no match");

    // minutes added
    alm_fields = tf(8'hB0, 8'hC5, 8'h00, 8'h00, 8'h00, 8'h00);
    tick(tf(8'h30, 8'h12, 8'h00, 8'h01, 8'h01, 8'h01));
    expect_at(0, 0, 1, "R1 minute differs");
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    expect_at(0, 1, 0, "R1 sec and min match");
    wr_flag(0);

    alarm_en = 0;
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    expect_at(0, 0, 1, "R3 alarm disabled");
    alarm_en = 1;

    alm_fields = '0;
    tick(tf(8'h07, 8'h33, 8'h05, 8'h21, 8'h09, 8'h03));
    expect_at(0, 1, 0, "R1 no field enabled matches");
    wr_flag(0);
    alm_fields = tf(8'hB0, 8'hC5, 8'h00, 8'h00, 8'h00, 8'h00);

    // auto clear
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    rd_status();
    expect_at(0, 1, 0, "R7 no auto clear when off");
    auto_clr_en = 1;
    rd_status();
    expect_at(0, 0, 1, "R7 auto clear on read");

    // match inside a read
    rd_busy = 1;
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    rd_status();
    expect_at(0, 1, 0, "R8 flag survives same read");
    rd_busy = 0;
    step();
    rd_busy = 1; status_rd = 1; step(); status_rd = 0; rd_busy = 0;
    expect_at(0, 0, 1, "R8 later read clears");
    auto_clr_en = 0;

    // set beats clear
    flag_wr = 1; flag_wr_bit = 0;
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    flag_wr = 0;
    expect_at(0, 1, 0, "R9 set wins over clear");
    wr_flag(0);

    // pulse mode
    irq_mode = 1;
    step();
    expect_at(0, 0, 1, "R5 idle pulse mode");
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    for (int k = 0; k < P; k++) expect_at(k, 1, 0, "R5 pulse low");
    expect_at(P, 1, 1, "R5 pulse ends, flag kept");
    repeat (P + 2) step();

    // restart
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    for (int k = 0; k < 3; k++) expect_at(k, 1, 0, "R5 first pulse");
    step(); step();
    tick(tf(8'h30, 8'h45, 8'h00, 8'h01, 8'h01, 8'h01));
    for (int k = 0; k < P; k++) expect_at(k, 1, 0, "R5 restarted pulse");
    expect_at(P, 1, 1, "R5 restarted pulse ends");
    repeat (P + 2) step();

    // frequency output override
    irq_mode = 0;
    fout_active = 1; fout_level = 1;
    expect_at(0, 1, 1, "R10 override high");
    step();
    fout_level = 0;
    expect_at(0, 1, 0, "R10 override low");
    step();
    fout_level = 1;
    wr_flag(0);
    expect_at(0, 0, 1, "R10 flag clears under override");
    fout_active = 0;
    expect_at(0, 0, 1, "R4 hold mode released");
    repeat (3) step();

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule